// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Start-Bit Qualification

This block turns an oversampled serial line into parallel characters. It is clocked by the system clock and advances on a sample enable that pulses sixteen times per bit period. A falling edge on the idle line begins a candidate start bit. The line is sampled again near the middle of that bit, and a high level there sends the receiver back to idle without assembling anything. Once the start bit is accepted, the receiver samples each data, parity and stop bit at its centre. The frame format comes from a small control word that sets the word length and the parity scheme.

A completed character goes into a one-deep holding register. The host sees the held byte and a status byte, and clears the status through two read strobes. The status byte carries data-ready, overrun, parity error, framing error and break. One sample period after each stop-bit sample, the receiver pulses a receive-ready event for every completed character.

Top module: `async_rx`

## Requirements
- R1: When the line falls and returns high before the midpoint of the start bit, 8 sample ticks after the edge is seen, no character is produced. Neither the status, the held byte nor the event changes.
- R2: Control bits [1:0] set the word length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data is received least significant bit first. Held bits above the word length read 0.
- R3: Control bit 3 enables the parity bit. With control bit 5 at 0, control bit 4 at 0 selects odd parity and 1 selects even parity. With control bit 5 at 1, the expected parity bit is 1 when control bit 4 is 0 and 0 when control bit 4 is 1. A mismatch sets status bit 2.
- R4: A first stop bit sampled low sets status bit 3, the framing error, and the character is still loaded. Control bit 2, the stop length, has no effect on reception.
- R5: A frame whose data bits, parity bit (when enabled) and stop bit are all 0 is a break. It loads the character 0x00, sets status bits 4 and 3, and does not set status bit 2.
- R6: A character that completes while status bit 0 is 1 sets status bit 1, the overrun flag. The held byte and the other flags stay unchanged.
- R7: Loading a character sets status bit 0, data ready. A pulse on the data read strobe clears it.
- R8: A pulse on the status read strobe clears status bits 1 to 4. Status bits 7 to 5 always read 0.
- R9: After reset, the held byte is 0x00, the status byte is 0x00 and the event output is low.
- R10: The receive-ready event is high for exactly one clock, on the first sample tick after the stop-bit sample. It fires once for each completed character, overruns included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_en | input | 1 | Sample tick, 16 per bit period |
| rx_line | input | 1 | Serial receive line, idle high |
| line_ctrl | input | 6 | Frame format: [1:0] word length, [2] stop length, [3] parity enable, [4] even/force-0, [5] force parity |
| rd_data | input | 1 | One-clock strobe: host read of the held byte |
| rd_status | input | 1 | One-clock strobe: host read of the status byte |
| held_data | output | 8 | Holding register contents |
| line_status | output | 8 | Status: [0] ready, [1] overrun, [2] parity, [3] framing, [4] break, [7:5] zero |
| rx_ready_evt | output | 1 | One-clock receive-ready event |

## Verification
Random frames cover all four word lengths, all five parity settings, both stop-length settings, occasional wrong parity bits and low stop bits. Because the host reads are random too, overruns and flag accumulation across frames also occur. Directed cases set the line patterns apart. A short low glitch must produce nothing, while a full frame with the same leading edge must produce a character. An all-zero frame must be reported as a break, while a frame that has nonzero data and a low stop bit must be reported only as a framing error. Forced-1 and forced-0 parity are each sent with a matching and a mismatching parity bit, so that they cannot be confused with odd or even parity.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       par_err;
        logic       frm_err;
        logic       brk;
    } rx_char_t;

    localparam int STS_READY = 0;
    localparam int STS_OVR   = 1;
    localparam int STS_PAR   = 2;
    localparam int STS_FRM   = 3;
    localparam int STS_BRK   = 4;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], line_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign line_o = sync_q[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import async_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sample_en,
    input  logic     rx_s,
    input  logic [1:0] len_sel,
    input  logic     par_en,
    input  logic     par_sel,
    input  logic     par_force,
    output logic     done_o,
    output rx_char_t char_o
);
    localparam int CNT_W   = $clog2(OSR);
    localparam int IDX_W   = $clog2(DATA_W);
    localparam int MID     = OSR / 2 - 1;
    localparam int MIN_LEN = DATA_W - 3;

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] shreg;
        logic              ones;
        logic              par_bit;
        logic              line_prev;
        logic              done;
        rx_char_t          chr;
    } fsm_t;

    fsm_t q, d;
    logic [IDX_W-1:0] last_idx;
    logic             exp_par;
    logic             bit_end;

    always_comb begin
        last_idx = IDX_W'(MIN_LEN - 1) + IDX_W'(len_sel);
        exp_par  = par_force ? ~par_sel : (par_sel ? ^q.shreg : ~^q.shreg);
        bit_end  = (q.cnt == CNT_W'(OSR - 1));
        d        = q;
        d.done   = 1'b0;
        if (sample_en) begin
            d.line_prev = rx_s;
            case (q.state)
                ST_IDLE: begin
                    if (q.line_prev && !rx_s) begin
                        d.state = ST_START;
                        d.cnt   = '0;
                    end
                end
                ST_START: begin
                    if (q.cnt == CNT_W'(MID)) begin
                        if (rx_s) begin
                            d.state = ST_IDLE;
                        end else begin
                            d.state = ST_DATA;
                            d.cnt   = '0;
                            d.idx   = '0;
                            d.shreg = '0;
                            d.ones  = 1'b0;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (bit_end) begin
                        d.cnt          = '0;
                        d.shreg[q.idx] = rx_s;
                        d.ones         = q.ones | rx_s;
                        if (q.idx == last_idx) d.state = par_en ? ST_PAR : ST_STOP;
                        else                   d.idx   = q.idx + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (bit_end) begin
                        d.cnt     = '0;
                        d.par_bit = rx_s;
                        d.ones    = q.ones | rx_s;
                        d.state   = ST_STOP;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (bit_end) begin
                        d.cnt           = '0;
                        d.state         = ST_IDLE;
                        d.done          = 1'b1;
                        d.chr.brk       = !q.ones && !rx_s;
                        d.chr.data      = d.chr.brk ? '0 : q.shreg;
                        d.chr.frm_err   = !rx_s;
                        d.chr.par_err   = par_en && (q.par_bit != exp_par) && !d.chr.brk;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.state     <= ST_IDLE;
            q.line_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign done_o = q.done;
    assign char_o = q.chr;

    // R1: a start bit found high at its midpoint returns to idle, no character
    p_false_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_START && sample_en && q.cnt == CNT_W'(MID) && rx_s)
        |=> (q.state == ST_IDLE && !q.done));

    // R5: a break always delivers a zero byte with framing error
    p_break_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.chr.brk) |-> (q.chr.data == '0 && q.chr.frm_err && !q.chr.par_err));

    // R10: completion is a single-cycle pulse
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
endmodule

// File: rtl/rx_hold_status.sv
module rx_hold_status
    import async_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              done_i,
    input  rx_char_t          char_i,
    input  logic              rd_data,
    input  logic              rd_status,
    output logic [DATA_W-1:0] held_o,
    output logic [7:0]        status_o,
    output logic              evt_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ready;
        logic              ovr;
        logic              perr;
        logic              ferr;
        logic              brk;
        logic              pend;
        logic              evt;
    } hs_t;

    hs_t q, d;

    always_comb begin
        d     = q;
        d.evt = 1'b0;
        if (rd_data)   d.ready = 1'b0;
        if (rd_status) begin
            d.ovr  = 1'b0;
            d.perr = 1'b0;
            d.ferr = 1'b0;
            d.brk  = 1'b0;
        end
        if (sample_en && q.pend) begin
            d.evt  = 1'b1;
            d.pend = 1'b0;
        end
        if (done_i) begin
            d.pend = 1'b1;
            if (q.ready) begin
                d.ovr = 1'b1;
            end else begin
                d.data  = char_i.data[DATA_W-1:0];
                d.ready = 1'b1;
                d.perr  = q.perr | char_i.par_err;
                d.ferr  = q.ferr | char_i.frm_err;
                d.brk   = q.brk  | char_i.brk;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        status_o            = '0;
        status_o[STS_READY] = q.ready;
        status_o[STS_OVR]   = q.ovr;
        status_o[STS_PAR]   = q.perr;
        status_o[STS_FRM]   = q.ferr;
        status_o[STS_BRK]   = q.brk;
    end
    assign held_o = q.data;
    assign evt_o  = q.evt;

    // R6: overrun keeps the held byte and raises the overrun flag
    p_overrun_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && q.ready) |=> (q.ovr && q.data == $past(q.data)));

    // R7: data read clears data ready when no character lands in the same cycle
    p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !done_i) |=> !q.ready);

    // R8: status read clears the error flags
    p_status_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !done_i) |=> !(q.ovr || q.perr || q.ferr || q.brk));

    // R10: the event lasts one clock
    p_evt_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.evt |=> !q.evt);
endmodule

// File: rtl/async_rx.sv
module async_rx
    import async_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              rx_line,
    input  logic [5:0]        line_ctrl,
    input  logic              rd_data,
    input  logic              rd_status,
    output logic [DATA_W-1:0] held_data,
    output logic [7:0]        line_status,
    output logic              rx_ready_evt
);
    logic     rx_s;
    logic     done;
    rx_char_t chr;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (rx_line),
        .line_o (rx_s)
    );

    rx_frame_fsm #(.DATA_W(DATA_W), .OSR(OSR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .rx_s      (rx_s),
        .len_sel   (line_ctrl[1:0]),
        .par_en    (line_ctrl[3]),
        .par_sel   (line_ctrl[4]),
        .par_force (line_ctrl[5]),
        .done_o    (done),
        .char_o    (chr)
    );

    rx_hold_status #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .done_i    (done),
        .char_i    (chr),
        .rd_data   (rd_data),
        .rd_status (rd_status),
        .held_o    (held_data),
        .status_o  (line_status),
        .evt_o     (rx_ready_evt)
    );
endmodule

// File: tb/async_rx_test.sv
module async_rx_test;
    localparam int TICK_DIV  = 4;
    localparam int BIT_CLKS  = TICK_DIV * 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_en = 1'b0;
    logic       rx_line = 1'b1;
    logic [5:0] line_ctrl = '0;
    logic       rd_data = 1'b0;
    logic       rd_status = 1'b0;
    logic [7:0] held_data;
    logic [7:0] line_status;
    logic       rx_ready_evt;

    int tests = 0;
    int fails = 0;
    int evt_seen = 0;
    int evt_exp = 0;
    int evt_wide = 0;
    bit finished = 0;

    logic [7:0] m_data = '0;
    logic m_dr = 0, m_oe = 0, m_pe = 0, m_fe = 0, m_bi = 0;

    async_rx uut (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rx_line(rx_line),
        .line_ctrl(line_ctrl), .rd_data(rd_data), .rd_status(rd_status),
        .held_data(held_data), .line_status(line_status), .rx_ready_evt(rx_ready_evt)
    );

    always #4 clk = ~clk;

    initial begin
        int tcnt = 0;
        forever begin
            @(negedge clk);
            tcnt = (tcnt + 1) % TICK_DIV;
            sample_en = (tcnt == 0);
        end
    end

    initial begin
        logic prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rx_ready_evt) begin
                evt_seen++;
                if (prev) evt_wide++;
            end
            prev = rx_ready_evt;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_status();
        return {3'b000, m_bi, m_fe, m_pe, m_oe, m_dr};
    endfunction

    function automatic logic exp_parity(input logic [7:0] dat, input logic [5:0] ctl);
        if (ctl[5]) return ~ctl[4];
        return ctl[4] ? ^dat : ~^dat;
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic v);
        rx_line = v;
        wait_clk(BIT_CLKS);
    endtask

    task automatic check_all(input string req);
        chk({req, " held"}, held_data, m_data);
        chk({req, " status"}, line_status, m_status());
        chk({req, " events"}, evt_seen, evt_exp);
    endtask

    // sends one frame, updates the model, checks the outputs
    task automatic frame(input string req, input logic [7:0] dat, input logic [5:0] ctl,
                         input logic bad_par, input logic stopv, input logic zero_par);
        int len;
        logic [7:0] md;
        logic pbit, brk;
        len = 5 + ctl[1:0];
        md = dat & ((8'd1 << len) - 8'd1);
        pbit = zero_par ? 1'b0 : (exp_parity(md, ctl) ^ bad_par);
        line_ctrl = ctl;
        send_bit(1'b0);
        for (int i = 0; i < len; i++) send_bit(md[i]);
        if (ctl[3]) send_bit(pbit);
        send_bit(stopv);
        send_bit(1'b1);
        wait_clk(8);
        brk = (md == 0) && (!ctl[3] || !pbit) && !stopv;
        evt_exp++;
        if (m_dr) m_oe = 1;
        else begin
            m_data = brk ? 8'h00 : md;
            m_dr = 1;
            m_fe |= !stopv;
            m_bi |= brk;
            m_pe |= ctl[3] && (pbit != exp_parity(md, ctl)) && !brk;
        end
        check_all(req);
    endtask

    task automatic read_data();
        rd_data = 1'b1; wait_clk(1); rd_data = 1'b0; wait_clk(1);
        m_dr = 0;
    endtask

    task automatic read_status();
        rd_status = 1'b1; wait_clk(1); rd_status = 1'b0; wait_clk(1);
        m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0;
    endtask

    task automatic clear_all();
        read_data(); read_status();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int seed = 32'h1d5e;
        void'($urandom(seed));
        wait_clk(5);
        // R9: reset state
        chk("R9 held", held_data, 8'h00);
        chk("R9 status", line_status, 8'h00);
        chk("R9 event", rx_ready_evt, 1'b0);
        rst_n = 1'b1;
        wait_clk(BIT_CLKS);

        // R2: 8-bit and 5-bit word lengths
        frame("R2 8bit", 8'hA5, 6'b000011, 0, 1, 0);
        read_data();
        chk("R7 ready cleared", line_status[0], 1'b0);
        frame("R2 5bit", 8'hFF, 6'b000000, 0, 1, 0);
        clear_all();
        frame("R2 6bit", 8'h2B, 6'b000001, 0, 1, 0);
        clear_all();

        // R3: each parity mode, good and bad parity bit
        for (int m = 0; m < 4; m++) begin
            logic [5:0] ctl;
            ctl = {m[1:0], 1'b1, 1'b0, 2'b10};
            frame("R3 good parity", 8'h5A, ctl, 0, 1, 0);
            clear_all();
            frame("R3 bad parity", 8'h5B, ctl, 1, 1, 0);
            clear_all();
        end

        // R4: low stop bit, two-stop setting
        frame("R4 framing", 8'h3C, 6'b000111, 0, 0, 0);
        clear_all();
        frame("R4 stop len", 8'hC3, 6'b000111, 0, 1, 0);
        clear_all();

        // R5: break frame with parity enabled
        frame("R5 break", 8'h00, 6'b001011, 0, 0, 1);
        chk("R5 break bits", line_status[4:2], 3'b110);
        clear_all();

        // R6: overrun keeps first byte
        frame("R6 first", 8'h11, 6'b000011, 0, 1, 0);
        frame("R6 overrun", 8'h22, 6'b000011, 1, 0, 0);
        chk("R6 held kept", held_data, 8'h11);
        read_status();
        chk("R8 cleared", line_status, 8'h01);
        read_data();
        chk("R7 cleared", line_status, 8'h00);

        // R1: glitch shorter than half a bit
        rx_line = 1'b0;
        wait_clk(5 * TICK_DIV);
        rx_line = 1'b1;
        wait_clk(3 * BIT_CLKS);
        check_all("R1 false start");

        // random frames with random host reads
        for (int n = 0; n < 40; n++) begin
            logic [5:0] ctl;
            logic [7:0] dat;
            logic bp, sv;
            ctl = 6'($urandom);
            dat = 8'($urandom);
            bp  = ($urandom % 5) == 0;
            sv  = ($urandom % 6) != 0;
            frame("R2 R3 R4 R6 random", dat, ctl, bp, sv, 0);
            if (($urandom % 4) != 0) read_data();
            if (($urandom % 2) != 0) read_status();
            chk("R8 random status", line_status, m_status());
        end

        chk("R10 event width", evt_wide, 0);
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule